// File: doc/BRIEF.md
# Zero-Idiom-Aware Register Rename Stage

This block is the rename stage of an out-of-order core. Each clock it takes a group of up to four decoded micro-ops. Each op carries a lane valid bit, an operation class, two architectural source indices and one architectural destination index. The stage reads the current physical tag of every source from an alias table. It hands each ordinary destination a fresh physical tag taken from a circular free list. For every destination it reports the tag that the destination held before the op, so that retire can later release that tag.

Some ops always produce zero when both sources name the same register: exclusive-or and subtract, in scalar and packed form, and packed signed greater-than compare. The stage resolves these ops itself. Their destination is pointed at physical tag 0, which permanently holds zero. They take no free-list entry and leave with their needs-execution flag cleared. A group may write the same architectural register several times. A later op in the group must see the tag given by the nearest earlier writer in that group, and all of this is resolved in one cycle.

Freed tags come back through a four-lane retire port. A group stalls, with inReady low, when the free list cannot cover the group's non-idiom destinations.

Top module: `zero_rename_stage`

## Requirements
- R1: With enough free tags, a group of four valid ops is accepted in a single cycle: outValid equals inValid and inReady is high.
- R2: A source that matches the destination of an earlier valid op in the same group gets that op's new tag from the latest such writer. Otherwise it gets the alias-table tag as it stood before the group.
- R3: Op classes are coded as 0 plain ALU, 1 XOR, 2 SUB, 3 packed XOR, 4 packed subtract, 5 packed compare-greater, 6 AND-NOT, 7 move. A valid op of class 1 to 5 whose two source indices are equal is a zero idiom. Its physDst is 0 and its needExec is 0.
- R4: A valid op of class 6 or 7 (also class 0), or of class 1 to 5 with unequal sources, is renamed normally with needExec 1, even when its sources are equal.
- R5: Every valid non-idiom op receives a nonzero tag taken from the free list in FIFO order. Tags within a group are distinct. Later groups read the new mapping.
- R6: prevDst of each valid op is the mapping of its destination just before that op, and this includes writes by earlier ops of the same group.
- R7: After reset, architectural register i maps to tag i+1, and the free list hands out tags 17 to 63 in ascending order.
- R8: When the free list holds fewer tags than the group's valid non-idiom ops, inReady and outValid are low. Neither the mapping nor the free list changes.
- R9: A group whose valid ops are all zero idioms is always accepted, even with an empty free list.
- R10: Each retire lane with retValid high appends its tag to the free list in lane order, and tag 0 is dropped. The appended tags are handed out after all tags already queued.
- R11: A lane with opValid low takes no tag, changes no mapping, is invisible to later lanes and has needExec 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | A group is offered |
| inReady | output | 1 | The free list covers the group's allocations |
| opValid | input | 4 | Per-lane op valid |
| opClass | input | 4x3 | Per-lane operation class |
| src1 | input | 4x4 | Per-lane first source index |
| src2 | input | 4x4 | Per-lane second source index |
| dst | input | 4x4 | Per-lane destination index |
| outValid | output | 1 | The group is renamed this cycle |
| physSrc1 | output | 4x6 | Physical tag of the first source |
| physSrc2 | output | 4x6 | Physical tag of the second source |
| physDst | output | 4x6 | New physical tag of the destination |
| prevDst | output | 4x6 | Earlier physical tag of the destination |
| needExec | output | 4 | The op must go to an execution unit |
| retValid | input | 4 | Per-lane retire valid |
| retTag | input | 4x6 | Tag released at retire |

## Verification
A corrupted alias-table entry stays hidden until some op names that register. It then shows in the same cycle as a wrong physSrc or prevDst tag. A fault in the free-list pointers or in the count shows as a repeated or out-of-order physDst on the next allocation. It can also show as inReady dropping or staying high at the wrong moment, which is noticed when the list is run close to empty. A fault in the in-group forwarding shows only on a chain of writes within one group, so the directed tests include chains to one register and reads of idiom results.

// File: rtl/rename_pkg.sv
package rename_pkg;
  localparam int P_LANES = 4;
  localparam int P_SLOTW = $clog2(P_LANES);
  localparam int P_CNTW  = $clog2(P_LANES + 1);

  typedef enum logic [2:0] {
    CL_ALU    = 3'd0,
    CL_XOR    = 3'd1,
    CL_SUB    = 3'd2,
    CL_VXOR   = 3'd3,
    CL_VSUB   = 3'd4,
    CL_VCMPGT = 3'd5,
    CL_ANDNOT = 3'd6,
    CL_MOVE   = 3'd7
  } opClass_t;

  // Strobes from control to datapath for one rename group
  typedef struct packed {
    logic                              fire;
    logic [P_LANES-1:0]                zeroIdiom;
    logic [P_LANES-1:0]                takeTag;
    logic [P_LANES-1:0][P_SLOTW-1:0]   slot;
    logic [P_CNTW-1:0]                 popCount;
  } strobes_t;

  function automatic logic isZeroClass(input logic [2:0] cls);
    return cls inside {CL_XOR, CL_SUB, CL_VXOR, CL_VSUB, CL_VCMPGT};
  endfunction
endpackage

// File: rtl/renamer_ctrl.sv
module renamer_ctrl
  import rename_pkg::*;
#(
  parameter int LANES = P_LANES,
  parameter int ARCH  = 16,
  parameter int PHYS  = 64,
  localparam int AW   = $clog2(ARCH),
  localparam int PW   = $clog2(PHYS),
  localparam int CW   = PW + 1
) (
  input  logic                         inValid,
  input  logic [LANES-1:0]             opValid,
  input  logic [LANES-1:0][2:0]        opClass,
  input  logic [LANES-1:0][AW-1:0]     src1,
  input  logic [LANES-1:0][AW-1:0]     src2,
  input  logic [CW-1:0]                freeCount,
  output logic                         inReady,
  output strobes_t                     strobes
);
  logic [P_CNTW-1:0] needTags;
  logic [LANES-1:0]  idiomLane;
  logic [LANES-1:0]  takeLane;
  logic [LANES-1:0][P_SLOTW-1:0] slotLane;

  // Idiom detection and prefix count of allocating lanes
  always_comb begin
    needTags = '0;
    for (int j = 0; j < LANES; j++) begin
      idiomLane[j] = opValid[j] && isZeroClass(opClass[j]) && (src1[j] == src2[j]);
      takeLane[j]  = opValid[j] && !idiomLane[j];
      slotLane[j]  = needTags[P_SLOTW-1:0];
      needTags     = needTags + P_CNTW'(takeLane[j]);
    end
  end

  assign inReady = (freeCount >= CW'(needTags));

  always_comb begin
    strobes.fire      = inValid && inReady;
    strobes.zeroIdiom = idiomLane;
    strobes.takeTag   = takeLane;
    strobes.slot      = slotLane;
    strobes.popCount  = strobes.fire ? needTags : '0;
  end
endmodule

// File: rtl/renamer_freelist.sv
module renamer_freelist
  import rename_pkg::*;
#(
  parameter int LANES = P_LANES,
  parameter int ARCH  = 16,
  parameter int PHYS  = 64,
  localparam int PW   = $clog2(PHYS),
  localparam int CW   = PW + 1,
  localparam int INIT = PHYS - ARCH - 1
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic [P_CNTW-1:0]          popCount,
  input  logic [LANES-1:0]           retValid,
  input  logic [LANES-1:0][PW-1:0]   retTag,
  output logic [LANES-1:0][PW-1:0]   headTags,
  output logic [CW-1:0]              freeCount
);
  logic [PW-1:0] slots [PHYS];
  logic [PW-1:0] headPtr;
  logic [PW-1:0] tailPtr;
  logic [CW-1:0] count;

  logic [LANES-1:0]         pushEn;
  logic [LANES-1:0][PW-1:0] pushAddr;
  logic [P_CNTW-1:0]        pushCnt;

  // Compact retired tags, dropping the zero register
  always_comb begin
    pushCnt = '0;
    for (int j = 0; j < LANES; j++) begin
      pushEn[j]   = retValid[j] && (retTag[j] != '0);
      pushAddr[j] = tailPtr + PW'(pushCnt);
      pushCnt     = pushCnt + P_CNTW'(pushEn[j]);
    end
  end

  for (genvar j = 0; j < LANES; j++) begin : g_head
    assign headTags[j] = slots[headPtr + PW'(j)];
  end

  assign freeCount = count;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int k = 0; k < PHYS; k++)
        slots[k] <= (k < INIT) ? PW'(k + ARCH + 1) : '0;
      headPtr <= '0;
      tailPtr <= PW'(INIT);
      count   <= CW'(INIT);
    end else begin
      for (int j = 0; j < LANES; j++)
        if (pushEn[j]) slots[pushAddr[j]] <= retTag[j];
      headPtr <= headPtr + PW'(popCount);
      tailPtr <= tailPtr + PW'(pushCnt);
      count   <= count + CW'(pushCnt) - CW'(popCount);
    end
  end
endmodule

// File: rtl/renamer_datapath.sv
module renamer_datapath
  import rename_pkg::*;
#(
  parameter int LANES = P_LANES,
  parameter int ARCH  = 16,
  parameter int PHYS  = 64,
  localparam int AW   = $clog2(ARCH),
  localparam int PW   = $clog2(PHYS)
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  strobes_t                   strobes,
  input  logic [LANES-1:0]           opValid,
  input  logic [LANES-1:0][AW-1:0]   src1,
  input  logic [LANES-1:0][AW-1:0]   src2,
  input  logic [LANES-1:0][AW-1:0]   dst,
  input  logic [LANES-1:0][PW-1:0]   headTags,
  output logic [LANES-1:0][PW-1:0]   physSrc1,
  output logic [LANES-1:0][PW-1:0]   physSrc2,
  output logic [LANES-1:0][PW-1:0]   physDst,
  output logic [LANES-1:0][PW-1:0]   prevDst,
  output logic [LANES-1:0]           needExec
);
  logic [PW-1:0] aliasTable [ARCH];
  logic [LANES-1:0][PW-1:0] newTag;

  for (genvar j = 0; j < LANES; j++) begin : g_new
    assign newTag[j] = strobes.zeroIdiom[j] ? '0 : headTags[strobes.slot[j]];
  end

  // Table lookup with forwarding from earlier lanes; the latest writer wins
  always_comb begin
    for (int j = 0; j < LANES; j++) begin
      physSrc1[j] = aliasTable[src1[j]];
      physSrc2[j] = aliasTable[src2[j]];
      prevDst[j]  = aliasTable[dst[j]];
      for (int k = 0; k < LANES; k++) begin
        if (k < j && opValid[k]) begin
          if (dst[k] == src1[j]) physSrc1[j] = newTag[k];
          if (dst[k] == src2[j]) physSrc2[j] = newTag[k];
          if (dst[k] == dst[j])  prevDst[j]  = newTag[k];
        end
      end
      physDst[j]  = newTag[j];
      needExec[j] = strobes.fire && strobes.takeTag[j];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < ARCH; i++)
        aliasTable[i] <= PW'(i + 1);
    end else if (strobes.fire) begin
      for (int j = 0; j < LANES; j++)
        if (opValid[j]) aliasTable[dst[j]] <= newTag[j];
    end
  end
endmodule

// File: rtl/zero_rename_stage.sv
module zero_rename_stage
  import rename_pkg::*;
#(
  parameter int ARCH  = 16,
  parameter int PHYS  = 64,
  localparam int LANES = P_LANES,
  localparam int AW   = $clog2(ARCH),
  localparam int PW   = $clog2(PHYS),
  localparam int CW   = PW + 1
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       inValid,
  output logic                       inReady,
  input  logic [LANES-1:0]           opValid,
  input  logic [LANES-1:0][2:0]      opClass,
  input  logic [LANES-1:0][AW-1:0]   src1,
  input  logic [LANES-1:0][AW-1:0]   src2,
  input  logic [LANES-1:0][AW-1:0]   dst,
  output logic                       outValid,
  output logic [LANES-1:0][PW-1:0]   physSrc1,
  output logic [LANES-1:0][PW-1:0]   physSrc2,
  output logic [LANES-1:0][PW-1:0]   physDst,
  output logic [LANES-1:0][PW-1:0]   prevDst,
  output logic [LANES-1:0]           needExec,
  input  logic [LANES-1:0]           retValid,
  input  logic [LANES-1:0][PW-1:0]   retTag
);
  strobes_t                  strobes;
  logic [CW-1:0]             freeCount;
  logic [LANES-1:0][PW-1:0]  headTags;

  renamer_ctrl #(.LANES(LANES), .ARCH(ARCH), .PHYS(PHYS)) i_ctrl (
    .inValid  (inValid),
    .opValid  (opValid),
    .opClass  (opClass),
    .src1     (src1),
    .src2     (src2),
    .freeCount(freeCount),
    .inReady  (inReady),
    .strobes  (strobes)
  );

  renamer_freelist #(.LANES(LANES), .ARCH(ARCH), .PHYS(PHYS)) i_free (
    .clk      (clk),
    .rstN     (rstN),
    .popCount (strobes.popCount),
    .retValid (retValid),
    .retTag   (retTag),
    .headTags (headTags),
    .freeCount(freeCount)
  );

  renamer_datapath #(.LANES(LANES), .ARCH(ARCH), .PHYS(PHYS)) i_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .opValid  (opValid),
    .src1     (src1),
    .src2     (src2),
    .dst      (dst),
    .headTags (headTags),
    .physSrc1 (physSrc1),
    .physSrc2 (physSrc2),
    .physDst  (physDst),
    .prevDst  (prevDst),
    .needExec (needExec)
  );

  assign outValid = strobes.fire;
endmodule

// File: rtl/renamer_checker.sv
module renamer_checker
  import rename_pkg::*;
#(
  parameter int ARCH  = 16,
  parameter int PHYS  = 64,
  localparam int LANES = P_LANES,
  localparam int AW   = $clog2(ARCH),
  localparam int PW   = $clog2(PHYS)
) (
  input logic                       clk,
  input logic                       rstN,
  input logic                       inValid,
  input logic                       inReady,
  input logic [LANES-1:0]           opValid,
  input logic [LANES-1:0][2:0]      opClass,
  input logic [LANES-1:0][AW-1:0]   src1,
  input logic [LANES-1:0][AW-1:0]   src2,
  input logic [LANES-1:0][AW-1:0]   dst,
  input logic                       outValid,
  input logic [LANES-1:0][PW-1:0]   physSrc1,
  input logic [LANES-1:0][PW-1:0]   physDst,
  input logic [LANES-1:0]           needExec
);
  logic [LANES-1:0] idiomSeen;
  logic             allIdiom;

  always_comb begin
    allIdiom = 1'b1;
    for (int j = 0; j < LANES; j++) begin
      idiomSeen[j] = opValid[j] && isZeroClass(opClass[j]) && (src1[j] == src2[j]);
      if (opValid[j] && !idiomSeen[j]) allIdiom = 1'b0;
    end
  end

  p_idiom_accept_r9: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && allIdiom) |-> inReady);

  p_stall_quiet_r8: assert property (@(posedge clk) disable iff (!rstN)
    !inReady |-> !outValid);

  for (genvar j = 0; j < LANES; j++) begin : g_lane
    p_idiom_zero_r3: assert property (@(posedge clk) disable iff (!rstN)
      (outValid && idiomSeen[j]) |-> (physDst[j] == '0 && !needExec[j]));

    p_fresh_tag_r5: assert property (@(posedge clk) disable iff (!rstN)
      (outValid && opValid[j] && !idiomSeen[j]) |-> (physDst[j] != '0 && needExec[j]));

    p_invalid_quiet_r11: assert property (@(posedge clk) disable iff (!rstN)
      (outValid && !opValid[j]) |-> !needExec[j]);

    if (j > 0) begin : g_fwd
      p_chain_fwd_r2: assert property (@(posedge clk) disable iff (!rstN)
        (outValid && opValid[j] && opValid[j-1] && dst[j-1] == src1[j])
          |-> (physSrc1[j] == physDst[j-1]));
    end
  end
endmodule

bind zero_rename_stage renamer_checker #(.ARCH(ARCH), .PHYS(PHYS)) i_chk (
  .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
  .opValid(opValid), .opClass(opClass), .src1(src1), .src2(src2), .dst(dst),
  .outValid(outValid), .physSrc1(physSrc1), .physDst(physDst), .needExec(needExec)
);

// File: tb/test_zero_rename_stage.sv
module test_zero_rename_stage;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0;
  logic inReady, outValid;
  logic [3:0]      opValid = '0;
  logic [3:0][2:0] opClass = '0;
  logic [3:0][3:0] src1 = '0, src2 = '0, dst = '0;
  logic [3:0][5:0] physSrc1, physSrc2, physDst, prevDst;
  logic [3:0]      needExec;
  logic [3:0]      retValid = '0;
  logic [3:0][5:0] retTag = '0;

  int checks = 0;
  int errors = 0;
  int refMap [16];
  int freeQ [$];

  always #(CLK_PERIOD/2) clk = ~clk;

  zero_rename_stage i_zero_rename_stage (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
    .opValid(opValid), .opClass(opClass), .src1(src1), .src2(src2), .dst(dst),
    .outValid(outValid), .physSrc1(physSrc1), .physSrc2(physSrc2),
    .physDst(physDst), .prevDst(prevDst), .needExec(needExec),
    .retValid(retValid), .retTag(retTag)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit refIdiom(input logic [2:0] c, input logic [3:0] a, input logic [3:0] b);
    return (c >= 3'd1 && c <= 3'd5) && (a == b);
  endfunction

  // Drives one group, checks every lane against the model, then commits the model
  task automatic runGroup(input logic [3:0] v, input logic [3:0][2:0] c,
                          input logic [3:0][3:0] a, input logic [3:0][3:0] b,
                          input logic [3:0][3:0] d, input string req);
    int t [16];
    int need, used, en;
    bit expReady, idm;
    @(negedge clk);
    inValid = 1'b1; opValid = v; opClass = c; src1 = a; src2 = b; dst = d;
    #1;
    need = 0;
    for (int j = 0; j < 4; j++) if (v[j] && !refIdiom(c[j], a[j], b[j])) need++;
    expReady = (need <= freeQ.size());
    chk(inReady == expReady, "R8 inReady", int'(inReady), int'(expReady));
    chk(outValid == expReady, (need == 4) ? "R1 outValid" : "R8 outValid",
        int'(outValid), int'(expReady));
    t = refMap;
    used = 0;
    if (expReady) begin
      for (int j = 0; j < 4; j++) begin
        if (!v[j]) begin
          chk(needExec[j] == 1'b0, "R11 needExec", int'(needExec[j]), 0);
          continue;
        end
        idm = refIdiom(c[j], a[j], b[j]);
        chk(physSrc1[j] == 6'(t[a[j]]), req, int'(physSrc1[j]), t[a[j]]);
        chk(physSrc2[j] == 6'(t[b[j]]), req, int'(physSrc2[j]), t[b[j]]);
        chk(prevDst[j] == 6'(t[d[j]]), "R6 prevDst", int'(prevDst[j]), t[d[j]]);
        en = idm ? 0 : freeQ[used];
        if (!idm) used++;
        chk(physDst[j] == 6'(en), idm ? "R3 physDst" : "R5 physDst", int'(physDst[j]), en);
        chk(needExec[j] == !idm, idm ? "R3 needExec" : "R4 needExec",
            int'(needExec[j]), int'(!idm));
        t[d[j]] = en;
      end
    end
    @(posedge clk);
    if (expReady) begin
      refMap = t;
      for (int k = 0; k < used; k++) void'(freeQ.pop_front());
    end
    #1 inValid = 1'b0; opValid = '0;
  endtask

  task automatic doRetire(input logic [3:0] v, input logic [3:0][5:0] tags);
    @(negedge clk);
    retValid = v; retTag = tags;
    @(posedge clk);
    for (int j = 0; j < 4; j++) if (v[j] && tags[j] != 0) freeQ.push_back(int'(tags[j]));
    #1 retValid = '0;
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk(inReady == 1'b1, "R7 idle ready", int'(inReady), 1);
    chk(outValid == 1'b0, "R7 idle outValid", int'(outValid), 0);
    runGroup(4'hF, '0, {4'd3, 4'd2, 4'd1, 4'd0}, {4'd7, 4'd6, 4'd5, 4'd4},
             {4'd11, 4'd10, 4'd9, 4'd8}, "R7 reset map");
  endtask

  task automatic t_chain;
    runGroup(4'hF, '0, {4'd5, 4'd5, 4'd5, 4'd5}, {4'd3, 4'd2, 4'd1, 4'd0},
             {4'd5, 4'd5, 4'd5, 4'd5}, "R2 chain");
    runGroup(4'hF, '0, {4'd5, 4'd6, 4'd6, 4'd5}, {4'd6, 4'd5, 4'd5, 4'd6},
             {4'd5, 4'd5, 4'd6, 4'd6}, "R2 cross");
  endtask

  task automatic t_idioms;
    runGroup(4'hF, {3'd4, 3'd3, 3'd2, 3'd1}, {4'd9, 4'd8, 4'd7, 4'd6},
             {4'd9, 4'd8, 4'd7, 4'd6}, {4'd3, 4'd2, 4'd1, 4'd0}, "R3 idioms");
    runGroup(4'hF, {3'd1, 3'd7, 3'd6, 3'd5}, {4'd2, 4'd4, 4'd4, 4'd4},
             {4'd3, 4'd4, 4'd4, 4'd4}, {4'd13, 4'd12, 4'd11, 4'd10}, "R4 non idioms");
    runGroup(4'hF, '0, {4'd10, 4'd2, 4'd1, 4'd0}, {4'd11, 4'd3, 4'd3, 4'd3},
             {4'd14, 4'd14, 4'd15, 4'd15}, "R3 read zero");
  endtask

  task automatic t_invalid;
    runGroup(4'b0101, '0, {4'd7, 4'd7, 4'd7, 4'd7}, {4'd1, 4'd1, 4'd1, 4'd1},
             {4'd7, 4'd7, 4'd7, 4'd7}, "R11 gaps");
  endtask

  task automatic t_exhaust;
    while (freeQ.size() >= 4)
      runGroup(4'hF, '0, {4'd1, 4'd2, 4'd3, 4'd4}, {4'd5, 4'd6, 4'd7, 4'd8},
               {4'd2, 4'd3, 4'd4, 4'd1}, "R5 drain");
    runGroup(4'hF, '0, {4'd0, 4'd1, 4'd2, 4'd3}, {4'd4, 4'd5, 4'd6, 4'd7},
             {4'd9, 4'd9, 4'd8, 4'd8}, "R8 stall");
    runGroup(4'hF, {3'd5, 3'd3, 3'd2, 3'd1}, {4'd1, 4'd2, 4'd3, 4'd4},
             {4'd1, 4'd2, 4'd3, 4'd4}, {4'd1, 4'd2, 4'd3, 4'd4}, "R9 idiom group");
    runGroup(4'hF, '0, {4'd1, 4'd2, 4'd3, 4'd4}, {4'd1, 4'd9, 4'd9, 4'd9},
             {4'd5, 4'd6, 4'd7, 4'd8}, "R9 read after idioms");
  endtask

  task automatic t_retire;
    doRetire(4'hF, {6'd21, 6'd0, 6'd20, 6'd0});
    doRetire(4'hF, {6'd25, 6'd24, 6'd23, 6'd22});
    chk(freeQ.size() >= 6, "R10 model size", freeQ.size(), 6);
    runGroup(4'hF, '0, {4'd8, 4'd7, 4'd6, 4'd5}, {4'd4, 4'd3, 4'd2, 4'd1},
             {4'd12, 4'd11, 4'd10, 4'd9}, "R10 reuse");
    runGroup(4'hF, '0, {4'd12, 4'd11, 4'd10, 4'd9}, {4'd0, 4'd0, 4'd0, 4'd0},
             {4'd15, 4'd14, 4'd13, 4'd12}, "R10 reuse");
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) refMap[i] = i + 1;
    for (int k = 17; k < 64; k++) freeQ.push_back(k);
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    t_reset();
    t_chain();
    t_idioms();
    t_invalid();
    t_exhaust();
    t_retire();
    repeat (2) @(posedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule